// File: doc/BRIEF.md
# Serial Voice Sample Receiver with Digital Attenuation

This block converts the serial receive stream of a voice interface into parallel 13-bit two's-complement samples, one per receive frame. The receive bit clock, the frame syncs, the serial data and a power-down flag are all slow signals. The block samples them with a fast system clock, so every edge it reacts to is an edge of a synchronized copy of a pin. A word starts at the first bit-clock falling edge at which the receive sync is seen high after having been low. The bits then arrive most significant first, one per falling edge.

Holding the receive bit clock at logic 1 while the transmit bit clock keeps running switches the block into an adjustment mode. In this mode the transmit bit clock paces the receiver and every word grows to 16 bits. The three trailing bits form an attenuation code, which is scaled onto the speech sample of the same frame in steps of about 3 dB, from 0 dB down to 21 dB. The output sample is forced to zero, the mid-scale level, in two cases: when the receive sync goes missing while the transmit sync continues, and while the part is powered down.

Top module: `rxd_pcm_rx`

## Requirements
- R1: With short sync (sync high at exactly one falling edge of the receive bit clock), 13 data bits are taken MSB first on that edge and the 12 falling edges after it. They appear as a signed value on `sample_o`, together with a `valid_o` pulse one system clock long, once per frame.
- R2: With long sync (sync high across two or more falling edges), only the falling edge at which sync is first seen high starts a word, and the captured sample is identical to the short-sync case.
- R3: Adjustment mode (`adj_mode_o` = 1) is entered only once the receive bit clock has been high for 16 consecutive falling edges of the transmit bit clock. After 15 such edges the flag is still 0.
- R4: In adjustment mode words are 16 bits long and are taken on transmit bit-clock falling edges: 13 speech bits MSB first, then a 3-bit code MSB first. The code appears on `atten_code_o`, and it is applied to the sample delivered for that same word.
- R5: For code k, the output is sign(x) * floor(|x| * M / 2^(8 + floor(k/2))), where M = 256 for even k and M = 181 for odd k. The result is therefore rounded toward zero, and code 000 passes the sample unchanged.
- R6: The first low level on the receive bit clock ends adjustment mode. The flag and the code clear together, and later words are 13 bits long at 0 dB.
- R7: Outside adjustment mode `atten_code_o` reads 000 and no attenuation is applied.
- R8: At each rising edge of the transmit sync, if no receive word has started since the previous transmit-sync rising edge, `sample_o` is set to zero without a `valid_o` pulse.
- R9: While `pwrdn_i` is high, `sample_o` is zero within a few system clocks, `valid_o` stays low and incoming words are dropped. Reception resumes once the flag falls.
- R10: `valid_o` never lasts longer than one system clock, and `sample_o` changes only when a `valid_o` pulse is issued or when it is set to zero.
- R11: After reset `sample_o`, `valid_o`, `atten_code_o` and `adj_mode_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clocks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_bclk_i | input | 1 | Receive bit clock; held at 1 to request adjustment mode |
| rx_fsync_i | input | 1 | Receive frame sync |
| rx_data_i | input | 1 | Serial receive data |
| tx_bclk_i | input | 1 | Transmit bit clock, used as the fallback bit clock in adjustment mode |
| tx_fsync_i | input | 1 | Transmit frame sync, the reference for missing-sync detection |
| pwrdn_i | input | 1 | Power-down request |
| sample_o | output | 13 | Attenuated two's-complement speech sample |
| valid_o | output | 1 | One-clock strobe marking a new sample |
| atten_code_o | output | 3 | Attenuation code currently in force |
| adj_mode_o | output | 1 | High while adjustment mode is active |

## Verification
A wrong bit count or a wrong word-length choice in the shifter shows up in the very frame it affects. The sample comes out shifted by one or three bit positions, or the code field lands inside the speech bits, and both can be seen on `sample_o` a few system clocks after the last falling edge. A fault in the mode-entry counter appears at the 15th or 16th transmit falling edge as an early or late `adj_mode_o`. A stale received-word flag only shows one frame period later, when the zeroing at the transmit sync either fails to happen or happens when it should not. For that reason the missing-sync scenario is observed across two silent frames.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int unsigned SPEECH_W = 13;
  localparam int unsigned CODE_W   = 3;

  typedef logic [CODE_W-1:0]   acode_t;
  typedef logic [SPEECH_W-1:0] sample_t;

  // index of each pin inside the synchronizer bundle
  localparam int unsigned PIN_RX_BCLK  = 0;
  localparam int unsigned PIN_RX_FSYNC = 1;
  localparam int unsigned PIN_RX_DATA  = 2;
  localparam int unsigned PIN_TX_BCLK  = 3;
  localparam int unsigned PIN_TX_FSYNC = 4;
  localparam int unsigned PIN_PWRDN    = 5;
  localparam int unsigned PIN_COUNT    = 6;

endpackage

// File: rtl/rxd_sync.sv
module rxd_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_i[b]};
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/rxd_mode_det.sv
module rxd_mode_det #(
  parameter int unsigned ENTRY_EDGES = 16
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic rx_bclk_lvl_i,
  input  logic tx_fall_i,
  output logic mode_o
);

  localparam int unsigned CNT_W = $clog2(ENTRY_EDGES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, mode_d;

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (!rx_bclk_lvl_i) begin
      cnt_d  = '0;
      mode_d = 1'b0;
    end else if (tx_fall_i && !mode_q) begin
      if (cnt_q == CNT_W'(ENTRY_EDGES - 1)) begin
        cnt_d  = '0;
        mode_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/rxd_shift.sv
module rxd_shift #(
  parameter int unsigned SW = 13,
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          bit_en_i,
  input  logic          fsync_i,
  input  logic          data_i,
  input  logic          long_word_i,
  output logic          start_o,
  output logic          done_o,
  output logic [SW-1:0] word_o,
  output logic [CW-1:0] coef_o
);

  localparam int unsigned LW    = SW + CW;
  localparam int unsigned CNT_W = $clog2(LW + 1);

  logic [LW-1:0]    sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             fs_prev_q, fs_prev_d;
  logic             long_q, long_d;
  logic             done_q, done_d;
  logic             start;
  logic [CNT_W-1:0] last_idx;

  assign start    = bit_en_i && fsync_i && !fs_prev_q && !hold_i;
  assign last_idx = long_q ? CNT_W'(LW - 1) : CNT_W'(SW - 1);

  always_comb begin
    sr_d      = sr_q;
    cnt_d     = cnt_q;
    busy_d    = busy_q;
    fs_prev_d = fs_prev_q;
    long_d    = long_q;
    done_d    = 1'b0;
    if (hold_i) begin
      busy_d = 1'b0;
    end else if (bit_en_i) begin
      fs_prev_d = fsync_i;
      if (start) begin
        sr_d   = {sr_q[LW-2:0], data_i};
        cnt_d  = CNT_W'(1);
        busy_d = 1'b1;
        long_d = long_word_i;
      end else if (busy_q) begin
        sr_d  = {sr_q[LW-2:0], data_i};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == last_idx) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sr_q      <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      fs_prev_q <= 1'b0;
      long_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      sr_q      <= sr_d;
      cnt_q     <= cnt_d;
      busy_q    <= busy_d;
      fs_prev_q <= fs_prev_d;
      long_q    <= long_d;
      done_q    <= done_d;
    end
  end

  assign start_o = start;
  assign done_o  = done_q;
  assign word_o  = long_q ? sr_q[LW-1:CW] : sr_q[SW-1:0];
  assign coef_o  = long_q ? sr_q[CW-1:0] : '0;

endmodule

// File: rtl/rxd_atten.sv
module rxd_atten #(
  parameter int unsigned SW = 13,
  parameter int unsigned CW = 3
) (
  input  logic [SW-1:0] sample_i,
  input  logic [CW-1:0] code_i,
  output logic [SW-1:0] sample_o
);

  localparam int unsigned FRAC = 8;
  localparam int unsigned PW   = SW + FRAC;

  logic          neg;
  logic [SW-1:0] mag;
  logic [PW-1:0] ext;
  logic [PW-1:0] prod;
  logic [SW-1:0] scaled;

  always_comb begin
    neg = sample_i[SW-1];
    mag = neg ? (~sample_i + SW'(1)) : sample_i;
    ext = PW'(mag);
    // odd codes: x * 181/256 (about -3 dB), even codes: x * 256/256
    if (code_i[0]) begin
      prod = (ext << 7) + (ext << 5) + (ext << 4) + (ext << 2) + ext;
    end else begin
      prod = ext << FRAC;
    end
    // each pair of codes adds a further halving (-6 dB); floor on magnitude
    scaled   = SW'(prod >> (FRAC + code_i[CW-1:1]));
    sample_o = neg ? (~scaled + SW'(1)) : scaled;
  end

endmodule

// File: rtl/rxd_pcm_rx.sv
module rxd_pcm_rx
  import rxd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ENTRY_EDGES = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_bclk_i,
  input  logic                rx_fsync_i,
  input  logic                rx_data_i,
  input  logic                tx_bclk_i,
  input  logic                tx_fsync_i,
  input  logic                pwrdn_i,
  output logic [SPEECH_W-1:0] sample_o,
  output logic                valid_o,
  output logic [CODE_W-1:0]   atten_code_o,
  output logic                adj_mode_o
);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  // pin synchronizers
  logic [PIN_COUNT-1:0] pins, pins_s;
  always_comb begin
    pins               = '0;
    pins[PIN_RX_BCLK]  = rx_bclk_i;
    pins[PIN_RX_FSYNC] = rx_fsync_i;
    pins[PIN_RX_DATA]  = rx_data_i;
    pins[PIN_TX_BCLK]  = tx_bclk_i;
    pins[PIN_TX_FSYNC] = tx_fsync_i;
    pins[PIN_PWRDN]    = pwrdn_i;
  end

  rxd_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .d_i   (pins),
    .q_o   (pins_s)
  );

  logic rx_bclk_s, rx_fsync_s, rx_data_s, tx_bclk_s, tx_fsync_s, pd_s;
  assign rx_bclk_s  = pins_s[PIN_RX_BCLK];
  assign rx_fsync_s = pins_s[PIN_RX_FSYNC];
  assign rx_data_s  = pins_s[PIN_RX_DATA];
  assign tx_bclk_s  = pins_s[PIN_TX_BCLK];
  assign tx_fsync_s = pins_s[PIN_TX_FSYNC];
  assign pd_s       = pins_s[PIN_PWRDN];

  // edge detection on the synchronized clocks and transmit sync
  logic rx_bclk_p_q, tx_bclk_p_q, tx_fsync_p_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rx_bclk_p_q  <= 1'b0;
      tx_bclk_p_q  <= 1'b0;
      tx_fsync_p_q <= 1'b0;
    end else begin
      rx_bclk_p_q  <= rx_bclk_s;
      tx_bclk_p_q  <= tx_bclk_s;
      tx_fsync_p_q <= tx_fsync_s;
    end
  end

  logic rx_fall, tx_fall, tx_fs_rise;
  assign rx_fall    = rx_bclk_p_q & ~rx_bclk_s;
  assign tx_fall    = tx_bclk_p_q & ~tx_bclk_s;
  assign tx_fs_rise = tx_fsync_s & ~tx_fsync_p_q;

  // adjustment-mode detection
  logic adj_mode;
  rxd_mode_det #(.ENTRY_EDGES(ENTRY_EDGES)) u_mode (
    .clk_i         (clk_i),
    .rst_n         (rst_n),
    .rx_bclk_lvl_i (rx_bclk_s),
    .tx_fall_i     (tx_fall),
    .mode_o        (adj_mode)
  );

  // deserializer, paced by the transmit clock while in adjustment mode
  logic          bit_en, word_start, word_done;
  sample_t       word;
  acode_t        coef;
  assign bit_en = adj_mode ? tx_fall : rx_fall;

  rxd_shift #(.SW(SPEECH_W), .CW(CODE_W)) u_shift (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .hold_i      (pd_s),
    .bit_en_i    (bit_en),
    .fsync_i     (rx_fsync_s),
    .data_i      (rx_data_s),
    .long_word_i (adj_mode),
    .start_o     (word_start),
    .done_o      (word_done),
    .word_o      (word),
    .coef_o      (coef)
  );

  sample_t scaled;
  rxd_atten #(.SW(SPEECH_W), .CW(CODE_W)) u_atten (
    .sample_i (word),
    .code_i   (coef),
    .sample_o (scaled)
  );

  // output registers
  sample_t sample_q, sample_d;
  acode_t  code_q, code_d;
  logic    valid_q, valid_d;
  logic    rx_seen_q, rx_seen_d;

  always_comb begin
    sample_d  = sample_q;
    code_d    = code_q;
    valid_d   = 1'b0;
    rx_seen_d = rx_seen_q;
    if (tx_fs_rise) begin
      if (!rx_seen_q) begin
        sample_d = '0;
      end
      rx_seen_d = 1'b0;
    end
    if (word_start) begin
      rx_seen_d = 1'b1;
    end
    if (word_done) begin
      sample_d = scaled;
      code_d   = coef;
      valid_d  = 1'b1;
    end
    if (!rx_bclk_s || !adj_mode) begin
      code_d = '0;
    end
    if (pd_s) begin
      sample_d = '0;
      valid_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sample_q  <= '0;
      code_q    <= '0;
      valid_q   <= 1'b0;
      rx_seen_q <= 1'b0;
    end else begin
      sample_q  <= sample_d;
      code_q    <= code_d;
      valid_q   <= valid_d;
      rx_seen_q <= rx_seen_d;
    end
  end

  assign sample_o     = sample_q;
  assign valid_o      = valid_q;
  assign atten_code_o = code_q;
  assign adj_mode_o   = adj_mode;

endmodule

// File: rtl/rxd_pcm_rx_chk.sv
module rxd_pcm_rx_chk
  import rxd_pkg::*;
(
  input logic                clk_i,
  input logic                rst_n,
  input logic                pd_s,
  input logic                rx_bclk_s,
  input logic                adj_mode_o,
  input logic [CODE_W-1:0]   atten_code_o,
  input logic [SPEECH_W-1:0] sample_o,
  input logic                valid_o
);

  assert_pd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    pd_s |=> (sample_o == '0) && !valid_o);

  assert_code_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !adj_mode_o |-> (atten_code_o == '0));

  assert_mode_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (adj_mode_o && !rx_bclk_s) |=> !adj_mode_o);

  assert_mode_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(adj_mode_o) |-> $past(rx_bclk_s));

  assert_single_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_sample_change_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(sample_o) |-> (valid_o || (sample_o == '0)));

endmodule

bind rxd_pcm_rx rxd_pcm_rx_chk u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n),
  .pd_s         (pd_s),
  .rx_bclk_s    (rx_bclk_s),
  .adj_mode_o   (adj_mode_o),
  .atten_code_o (atten_code_o),
  .sample_o     (sample_o),
  .valid_o      (valid_o)
);

// File: tb/rxd_pcm_rx_tb_top.sv
module rxd_pcm_rx_tb_top;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_bclk = 1'b0, rx_fsync = 1'b0, rx_data = 1'b0;
  logic        tx_bclk = 1'b0, tx_fsync = 1'b0, pwrdn = 1'b0;
  logic [12:0] sample;
  logic        valid;
  logic [2:0]  code;
  logic        mode;

  int checks = 0;
  int errors = 0;
  int vcnt   = 0;

  always #10 clk = ~clk;

  rxd_pcm_rx dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_bclk_i    (rx_bclk),
    .rx_fsync_i   (rx_fsync),
    .rx_data_i    (rx_data),
    .tx_bclk_i    (tx_bclk),
    .tx_fsync_i   (tx_fsync),
    .pwrdn_i      (pwrdn),
    .sample_o     (sample),
    .valid_o      (valid),
    .atten_code_o (code),
    .adj_mode_o   (mode)
  );

  always @(negedge clk) if (valid) vcnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_att(input int v, input int k);
    int mag, m, r;
    mag = (v < 0) ? -v : v;
    m   = (k % 2 == 1) ? mag * 181 : mag * 256;
    r   = m >>> (8 + k / 2);
    return (v < 0) ? -r : r;
  endfunction

  function automatic int s13(input logic [12:0] x);
    return int'($signed(x));
  endfunction

  // one bit period: clocks rise with data and sync, fall HALF clocks later
  task automatic bit_cycle(input bit adj, input bit rfs, input bit tfs, input bit d);
    @(negedge clk);
    tx_bclk = 1'b1; rx_bclk = 1'b1;
    rx_fsync = rfs; tx_fsync = tfs; rx_data = d;
    repeat (HALF) @(negedge clk);
    tx_bclk = 1'b0;
    if (!adj) rx_bclk = 1'b0;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits, input bit adj,
                            input bit long_fs, input bit rx_fs_en);
    for (int i = 0; i < nbits; i++) begin
      bit fs;
      fs = (i == 0) || (long_fs && i == 1);
      bit_cycle(adj, fs && rx_fs_en, fs, w[nbits-1-i]);
    end
    for (int i = 0; i < 4; i++) bit_cycle(adj, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 sample", s13(sample), 0);
    check("R11 valid", int'(valid), 0);
    check("R11 code", int'(code), 0);
    check("R11 mode", int'(mode), 0);
  endtask

  task automatic t_short_sync;
    int v0;
    v0 = vcnt;
    send_frame({3'b0, 13'(1234)}, 13, 1'b0, 1'b0, 1'b1);
    check("R1 sample", s13(sample), 1234);
    check("R1 one strobe", vcnt - v0, 1);
    send_frame({3'b0, 13'(-4096)}, 13, 1'b0, 1'b0, 1'b1);
    check("R1 most negative", s13(sample), -4096);
    send_frame({3'b0, 13'(4095)}, 13, 1'b0, 1'b0, 1'b1);
    check("R1 most positive", s13(sample), 4095);
    check("R7 code outside mode", int'(code), 0);
  endtask

  task automatic t_long_sync;
    int v0;
    v0 = vcnt;
    send_frame({3'b0, 13'(-77)}, 13, 1'b0, 1'b1, 1'b1);
    check("R2 long sync sample", s13(sample), -77);
    check("R2 one strobe", vcnt - v0, 1);
  endtask

  task automatic t_mode_entry;
    for (int i = 0; i < 15; i++) bit_cycle(1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 not after 15 edges", int'(mode), 0);
    bit_cycle(1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 entered after 16 edges", int'(mode), 1);
  endtask

  task automatic t_adjust;
    int vals[8] = '{-3001, 4095, -4096, 1, -1, 2047, -1000, 3333};
    for (int k = 0; k < 8; k++) begin
      logic [12:0] sv;
      logic [2:0]  kc;
      sv = 13'(vals[k]);
      kc = 3'(k);
      send_frame({sv, kc}, 16, 1'b1, 1'b0, 1'b1);
      check("R4 code shown", int'(code), k);
      check("R5 attenuated sample", s13(sample), exp_att(vals[k], k));
    end
    check("R4 mode kept", int'(mode), 1);
  endtask

  task automatic t_mode_exit;
    @(negedge clk);
    rx_bclk = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 mode cleared", int'(mode), 0);
    check("R6 code cleared", int'(code), 0);
    send_frame({3'b0, 13'(-1234)}, 13, 1'b0, 1'b0, 1'b1);
    check("R6 13-bit word at 0 dB", s13(sample), -1234);
  endtask

  task automatic t_missing_sync;
    int v0;
    send_frame({3'b0, 13'(500)}, 13, 1'b0, 1'b0, 1'b1);
    check("R8 baseline", s13(sample), 500);
    v0 = vcnt;
    send_frame({3'b0, 13'(999)}, 13, 1'b0, 1'b0, 1'b0);
    check("R8 held after one silent frame", s13(sample), 500);
    send_frame({3'b0, 13'(999)}, 13, 1'b0, 1'b0, 1'b0);
    check("R8 zero after silent frame period", s13(sample), 0);
    check("R8 no strobe", vcnt - v0, 0);
  endtask

  task automatic t_powerdown;
    int v0;
    send_frame({3'b0, 13'(123)}, 13, 1'b0, 1'b0, 1'b1);
    check("R9 baseline", s13(sample), 123);
    @(negedge clk);
    pwrdn = 1'b1;
    repeat (8) @(negedge clk);
    check("R9 zero on power-down", s13(sample), 0);
    v0 = vcnt;
    send_frame({3'b0, 13'(321)}, 13, 1'b0, 1'b0, 1'b1);
    check("R9 word dropped", s13(sample), 0);
    check("R9 no strobe", vcnt - v0, 0);
    @(negedge clk);
    pwrdn = 1'b0;
    repeat (8) @(negedge clk);
    send_frame({3'b0, 13'(77)}, 13, 1'b0, 1'b0, 1'b1);
    check("R9 resumes", s13(sample), 77);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_short_sync();
    t_long_sync();
    t_mode_entry();
    t_adjust();
    t_mode_exit();
    t_missing_sync();
    t_powerdown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule